// File: doc/BRIEF.md
# GPIO Pad Event Detector

This block watches one group of general-purpose input pads, up to 32 of them, and turns activity on each pad into a latched interrupt status bit. Each pad has its own 2-bit detection mode and its own polarity-invert bit. Together these select level sensing, single-edge sensing, both-edge sensing or no sensing at all. Setting the invert bit turns a rising-edge detector into a falling-edge one, and a high-level detector into a low-level one.

Software sees two per-pad bit vectors. The pending vector is cleared by writing ones to it. The enable vector is written whole. A single request line is high whenever any pad is both pending and enabled. A per-group ownership input gates the hardware: while another agent owns the group, no pad can become pending, but software clears still take effect. The pad inputs are expected to be synchronised to the clock before they reach this block.

Top module: `gpio_evt_detector`

## Requirements
- R1: In level mode (mode code 0) a pad's status bit is set in every cycle in which its polarity-adjusted input is 1. It therefore sets again after a clear for as long as the level persists.
- R2: In single-edge mode (mode code 1) a status bit is set when the polarity-adjusted input is 1 at a clock edge and was 0 at the previous clock edge.
- R3: The polarity-adjusted input is the pad input XOR the pad's invert bit. The same invert bit is applied to the current and to the previous sample, so toggling the invert bit while the pad is steady creates no edge.
- R4: In disabled mode (mode code 2) a pad never sets its status bit.
- R5: In both-edge mode (mode code 3) a status bit is set whenever the polarity-adjusted input differs from its value at the previous clock edge.
- R6: A clear strobe clears every status bit whose clear-data bit is 1 and leaves the bits whose clear-data bit is 0 unchanged. Without a clear strobe, no status bit ever falls.
- R7: When a detected event and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: An enable strobe loads the enable vector, which otherwise holds. The request output is the OR over all pads of status AND enable, and it is low whenever the enable vector is zero.
- R9: While the group ownership input is 0, no status bit becomes set, and clears still work.
- R10: Reset clears the status, enable and previous-sample registers. A pad that reads 1 on the first cycle after reset in edge mode with invert clear therefore counts as a rising edge.
- R11: The mode field of pad i sits in bits 2i+1:2i of the mode vector. Pad i maps to bit i of every other per-pad vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pad_i | input | NUM_PADS | Synchronised pad levels |
| mode_i | input | 2*NUM_PADS | Per-pad detection mode, 2 bits per pad |
| inv_i | input | NUM_PADS | Per-pad polarity invert |
| host_own_i | input | 1 | Group owned by this host; 0 blocks status setting |
| clr_wr_i | input | 1 | Clear strobe for the status vector |
| clr_wdata_i | input | NUM_PADS | Ones select the status bits to clear |
| en_wr_i | input | 1 | Load strobe for the enable vector |
| en_wdata_i | input | NUM_PADS | New enable vector |
| status_o | output | NUM_PADS | Pending status vector |
| enable_o | output | NUM_PADS | Enable vector |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench aims at the places where the detector can get the order of events wrong. One is a clear that lands in the same cycle as a new edge; a design that lets the clear win drops that interrupt. Another is a level that is still asserted when it is cleared; a design that latches only once would go quiet. A third is toggling the invert bit on a steady pad; a design that stores the inverted sample would raise a false edge. Ownership loss is checked for both halves of its rule, events suppressed and clears honoured. A design that froze the whole register would leave stale bits pending. Randomised mixes of modes, polarities, pads and strobes then compare status, enable and request against a bench model in every cycle.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    typedef enum logic [1:0] {
        EVT_LEVEL = 2'd0,
        EVT_EDGE  = 2'd1,
        EVT_OFF   = 2'd2,
        EVT_BOTH  = 2'd3
    } evt_mode_e;

    localparam int MODE_W = 2;

endpackage

// File: rtl/gpio_evt_cell.sv
module gpio_evt_cell
    import gpio_evt_pkg::*;
(
    input  logic             cur_i,
    input  logic             prev_i,
    input  logic             inv_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic             own_i,
    output logic             hit_o
);
    logic      adj_cur;
    logic      adj_prev;
    logic      raw_hit;
    evt_mode_e mode;

    always_comb begin
        mode     = evt_mode_e'(mode_i);
        // polarity applied to both samples: an invert toggle alone is no edge
        adj_cur  = cur_i ^ inv_i;
        adj_prev = prev_i ^ inv_i;
        unique case (mode)
            EVT_LEVEL: raw_hit = adj_cur;
            EVT_EDGE:  raw_hit = adj_cur & ~adj_prev;
            EVT_OFF:   raw_hit = 1'b0;
            EVT_BOTH:  raw_hit = adj_cur ^ adj_prev;
            default:   raw_hit = 1'b0;
        endcase
        hit_o = raw_hit & own_i;
    end
endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs #(
    parameter int NUM_PADS = 32
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PADS-1:0] pad_i,
    input  logic [NUM_PADS-1:0] hit_i,
    input  logic                clr_wr_i,
    input  logic [NUM_PADS-1:0] clr_wdata_i,
    input  logic                en_wr_i,
    input  logic [NUM_PADS-1:0] en_wdata_i,
    output logic [NUM_PADS-1:0] prev_o,
    output logic [NUM_PADS-1:0] status_o,
    output logic [NUM_PADS-1:0] enable_o
);
    typedef struct packed {
        logic [NUM_PADS-1:0] prev;
        logic [NUM_PADS-1:0] status;
        logic [NUM_PADS-1:0] enable;
    } regs_t;

    regs_t st_d, st_q;
    logic [NUM_PADS-1:0] clr_mask;

    always_comb begin
        st_d      = st_q;
        clr_mask  = clr_wr_i ? clr_wdata_i : '0;
        st_d.prev = pad_i;
        // a fresh event overrides a clear of the same bit
        st_d.status = (st_q.status & ~clr_mask) | hit_i;
        if (en_wr_i) begin
            st_d.enable = en_wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prev_o   = st_q.prev;
    assign status_o = st_q.status;
    assign enable_o = st_q.enable;
endmodule

// File: rtl/gpio_evt_detector.sv
module gpio_evt_detector
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PADS = 32
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [NUM_PADS-1:0]        pad_i,
    input  logic [MODE_W*NUM_PADS-1:0] mode_i,
    input  logic [NUM_PADS-1:0]        inv_i,
    input  logic                       host_own_i,
    input  logic                       clr_wr_i,
    input  logic [NUM_PADS-1:0]        clr_wdata_i,
    input  logic                       en_wr_i,
    input  logic [NUM_PADS-1:0]        en_wdata_i,
    output logic [NUM_PADS-1:0]        status_o,
    output logic [NUM_PADS-1:0]        enable_o,
    output logic                       irq_o
);
    logic [NUM_PADS-1:0] prev_q;
    logic [NUM_PADS-1:0] hit;
    logic [NUM_PADS-1:0] status_q;
    logic [NUM_PADS-1:0] enable_q;

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
        gpio_evt_cell u_cell (
            .cur_i  (pad_i[i]),
            .prev_i (prev_q[i]),
            .inv_i  (inv_i[i]),
            .mode_i (mode_i[MODE_W*i +: MODE_W]),
            .own_i  (host_own_i),
            .hit_o  (hit[i])
        );
    end

    gpio_evt_regs #(.NUM_PADS(NUM_PADS)) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pad_i       (pad_i),
        .hit_i       (hit),
        .clr_wr_i    (clr_wr_i),
        .clr_wdata_i (clr_wdata_i),
        .en_wr_i     (en_wr_i),
        .en_wdata_i  (en_wdata_i),
        .prev_o      (prev_q),
        .status_o    (status_q),
        .enable_o    (enable_q)
    );

    assign status_o = status_q;
    assign enable_o = enable_q;
    assign irq_o    = |(status_q & enable_q);
endmodule

// File: rtl/gpio_evt_detector_chk.sv
module gpio_evt_detector_chk #(
    parameter int NUM_PADS = 32
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                host_own_i,
    input logic                clr_wr_i,
    input logic [NUM_PADS-1:0] clr_wdata_i,
    input logic                en_wr_i,
    input logic [NUM_PADS-1:0] en_wdata_i,
    input logic [NUM_PADS-1:0] status_o,
    input logic [NUM_PADS-1:0] enable_o,
    input logic                irq_o
);
    // R6: with ownership off no event can refill, so cleared bits read 0
    a_r6_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_wr_i && !host_own_i) |=> ((status_o & $past(clr_wdata_i)) == '0));

    // R6: status bits only fall on a clear strobe
    a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_wr_i |=> ((~status_o & $past(status_o)) == '0));

    // R9: no bit rises while the group is owned elsewhere
    a_r9_no_set_unowned: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !host_own_i |=> ((status_o & ~$past(status_o)) == '0));

    // R8: enable load and hold
    a_r8_enable_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_wr_i |=> (enable_o == $past(en_wdata_i)));

    a_r8_enable_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_wr_i |=> $stable(enable_o));

    // R8: fully masked means no request
    a_r8_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_o == '0) |-> !irq_o);
endmodule

bind gpio_evt_detector gpio_evt_detector_chk #(.NUM_PADS(NUM_PADS)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .host_own_i  (host_own_i),
    .clr_wr_i    (clr_wr_i),
    .clr_wdata_i (clr_wdata_i),
    .en_wr_i     (en_wr_i),
    .en_wdata_i  (en_wdata_i),
    .status_o    (status_o),
    .enable_o    (enable_o),
    .irq_o       (irq_o)
);

// File: tb/gpio_evt_detector_tb.sv
module gpio_evt_detector_tb;
    localparam int N = 32;

    logic           clk_i = 1'b0;
    logic           rst_ni = 1'b0;
    logic [N-1:0]   pad_i = '0;
    logic [2*N-1:0] mode_i = '0;
    logic [N-1:0]   inv_i = '0;
    logic           host_own_i = 1'b1;
    logic           clr_wr_i = 1'b0;
    logic [N-1:0]   clr_wdata_i = '0;
    logic           en_wr_i = 1'b0;
    logic [N-1:0]   en_wdata_i = '0;
    logic [N-1:0]   status_o;
    logic [N-1:0]   enable_o;
    logic           irq_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [N-1:0] m_prev = '0;
    logic [N-1:0] m_stat = '0;
    logic [N-1:0] m_en = '0;

    always #5 clk_i = ~clk_i;

    gpio_evt_detector #(.NUM_PADS(N)) u_dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .pad_i(pad_i), .mode_i(mode_i),
        .inv_i(inv_i), .host_own_i(host_own_i), .clr_wr_i(clr_wr_i),
        .clr_wdata_i(clr_wdata_i), .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
        .status_o(status_o), .enable_o(enable_o), .irq_o(irq_o)
    );

    // expected events from the mode rules R1..R5 and R9
    function automatic logic [N-1:0] exp_hit(logic [N-1:0] pad, logic [N-1:0] prv,
                                             logic [N-1:0] inv, logic [2*N-1:0] md,
                                             logic own);
        logic [N-1:0] r;
        r = '0;
        for (int i = 0; i < N; i++) begin
            logic c, p;
            c = pad[i] ^ inv[i];
            p = prv[i] ^ inv[i];
            case (md[2*i +: 2])
                2'd0: r[i] = c;
                2'd1: r[i] = c & ~p;
                2'd2: r[i] = 1'b0;
                default: r[i] = c ^ p;
            endcase
        end
        return own ? r : '0;
    endfunction

    task automatic compare(string tag);
        logic exp_irq;
        exp_irq = |(m_stat & m_en);
        n_chk++;
        if (status_o !== m_stat || enable_o !== m_en || irq_o !== exp_irq) begin
            n_bad++;
            $display("FAIL %s: status=%h enable=%h irq=%b expected status=%h enable=%h irq=%b",
                     tag, status_o, enable_o, irq_o, m_stat, m_en, exp_irq);
        end
    endtask

    task automatic step(string tag);
        logic [N-1:0] h;
        @(posedge clk_i);
        h = exp_hit(pad_i, m_prev, inv_i, mode_i, host_own_i);
        m_stat = (clr_wr_i ? (m_stat & ~clr_wdata_i) : m_stat) | h;
        if (en_wr_i) m_en = en_wdata_i;
        m_prev = pad_i;
        @(negedge clk_i);
        compare(tag);
        clr_wr_i = 1'b0;
        en_wr_i  = 1'b0;
    endtask

    task automatic clear(logic [N-1:0] m);
        clr_wr_i = 1'b1;
        clr_wdata_i = m;
    endtask

    initial begin
        repeat (150000) @(posedge clk_i);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        compare("R10 reset state");

        // R10: prev cleared by reset, so an all-high pad is a rising edge
        mode_i = {N{2'b01}};
        pad_i = '1;
        step("R10 first edge after reset");
        clear('1);
        step("R6 clear all while steady");
        step("R2 steady high no edge");

        // R2 rising edges on a pattern; R11 per-pad positions
        pad_i = '0;  step("R2 falling not detected");
        pad_i = 32'h8000_0001; step("R11 edge on pads 0 and 31");
        clear(32'h0000_0001); step("R6 partial clear");
        clear('0); step("R6 write zero no effect");

        // R3 inverted edge = falling
        clear('1); inv_i = '1; step("R3 invert toggle no edge");
        pad_i = '0; step("R3 falling with invert");
        inv_i = '0; step("R3 invert toggle back no edge");

        // R1 level re-sets after clear
        clear('1); mode_i = '0; pad_i = 32'h0000_00F0; step("R1 level high");
        clear('1); step("R1 level re-sets after clear");
        pad_i = '0; clear('1); step("R1 level gone clears");
        inv_i = 32'h0000_0F00; step("R3 active-low level");
        inv_i = '0; clear('1); step("R1 clean");

        // R7 event beats clear
        mode_i = {N{2'b01}}; step("R7 setup");
        pad_i = 32'h00FF_0000; clear('1); step("R7 event wins over clear");

        // R4 disabled
        clear('1); mode_i = {N{2'b10}}; pad_i = '0; step("R4 setup");
        pad_i = '1; step("R4 rise ignored");
        pad_i = '0; step("R4 fall ignored");

        // R5 both edges
        mode_i = {N{2'b11}}; pad_i = 32'h0000_FFFF; step("R5 rise");
        clear('1); pad_i = '0; step("R5 fall");

        // R8 enable and request
        en_wr_i = 1'b1; en_wdata_i = 32'h0000_0001; step("R8 enable pad 0");
        clear(32'hFFFF_FFFE); step("R8 irq from pad 0");
        clear(32'h0000_0001); step("R8 irq drops after clear");
        en_wr_i = 1'b1; en_wdata_i = '0; pad_i = '1; step("R8 masked");

        // R9 ownership
        clear('1); host_own_i = 1'b0; mode_i = '0; step("R9 clear while unowned");
        pad_i = '0; step("R9 no set while unowned");
        host_own_i = 1'b1; pad_i = '1; step("R9 owned again level sets");

        // random mix
        for (int k = 0; k < 4000; k++) begin
            pad_i = $urandom;
            if ($urandom % 8 == 0) inv_i = $urandom;
            if ($urandom % 16 == 0) mode_i = {$urandom, $urandom};
            host_own_i = ($urandom % 8) != 0;
            if ($urandom % 4 == 0) clear($urandom);
            if ($urandom % 8 == 0) begin
                en_wr_i = 1'b1;
                en_wdata_i = $urandom;
            end
            step("R1/R2/R5/R6/R8 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule